// File: doc/BRIEF.md
# Tile-Scroll Video Address Counter

This block holds the working video-memory address that a tile-based renderer walks through the tilemap, together with a temporary address that records the top-left corner of the visible screen. The working address has two roles. The CPU uses it as a pointer through the address and data ports. During rendering it serves as a scroll counter that steps as tiles are fetched and reloads from the temporary address at fixed dots of each line.

A timing generator supplies the current dot and scanline numbers. The block decodes from them the dots on which coarse X advances, fine Y and the tile row advance, and the horizontal or vertical part of the temporary address is copied back. The CPU loads the temporary address through two byte writes to the address port, and the second write transfers it into the working address. A data-port access steps the working address linearly when rendering is idle. While rendering is active, the same access triggers both scroll increments at once.

Top module: `tile_addr_walker`

## Requirements
- R1: After reset the working address `vaddr` is 0 and the next address-port write counts as the first write of a pair.
- R2: The working address is split from MSB to LSB into fine Y (bits 14:12), nametable select (bits 11:10), coarse Y (bits 9:5) and coarse X (bits 4:0), and the field outputs present exactly these slices.
- R3: A first address-port write puts `wdata[6:0]` into temporary bits 14:8 and leaves `vaddr` unchanged. The second write puts `wdata` into temporary bits 7:0 and loads the complete temporary value into `vaddr` on the next cycle. This copy overrides any rendering step that falls in the same cycle.
- R4: Rendering is active when `render_en` is 1 and the line is a visible line (0..239) or the pre-render line (261). While it is active, coarse X increments at dots 8, 16, ..., 256 and at dots 328 and 336, which gives 34 steps per line. When coarse X wraps from 31 to 0, nametable bit 10 toggles.
- R5: While rendering is active, dot 256 increments fine Y. When fine Y wraps from 7, coarse Y advances. Coarse Y 29 wraps to 0 and toggles nametable bit 11. Coarse Y 31 wraps to 0 without a toggle.
- R6: While rendering is active, dot 257 copies coarse X and nametable bit 10 from the temporary address.
- R7: On the pre-render line with `render_en` set, every dot from 280 to 304 copies fine Y, nametable bit 11 and coarse Y from the temporary address.
- R8: When `render_en` is 0, or the line is outside the visible and pre-render lines, no scheduled increment or copy takes place.
- R9: A data-port access while rendering is active performs one coarse-X step and one fine-Y step. If it falls on a scheduled increment dot, the address still steps only once in each direction.
- R10: A data-port access while rendering is not active adds 32 when `step32` is 1 and 1 otherwise, wrapping within 15 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot | input | 9 | Current dot within the line |
| line | input | 9 | Current scanline number |
| render_en | input | 1 | Background or sprite rendering enabled |
| addr_wr | input | 1 | Write strobe for the address port |
| wdata | input | 8 | Byte written to the address port |
| data_acc | input | 1 | Data-port read or write strobe |
| step32 | input | 1 | Linear step size select for idle data accesses |
| vaddr | output | 15 | Working address |
| coarse_x | output | 5 | Coarse X field of the working address |
| coarse_y | output | 5 | Coarse Y field of the working address |
| nt_sel | output | 2 | Nametable select field |
| fine_y | output | 3 | Fine Y field |

## Verification
Two events can land in the same clock cycle. A data-port access can coincide with the scheduled dot-256 step. The bench provokes this case, and the expected result is a single coarse-X step and a single fine-Y step, not two of each. The bench also completes a second address-port write on a scheduled coarse-X dot while rendering is active. In that case the loaded byte pair must appear unchanged, with no increment applied on top of it.

// File: rtl/tile_addr_walker.sv
module tile_addr_walker #(
  parameter int DOT_W       = 9,
  parameter int LINE_W      = 9,
  parameter int VIS_LINES   = 240,
  parameter int PRE_LINE    = 261,
  parameter int FETCH_END   = 256,
  parameter int HCOPY_DOT   = 257,
  parameter int PREF_FIRST  = 328,
  parameter int PREF_LAST   = 336,
  parameter int VCOPY_FIRST = 280,
  parameter int VCOPY_LAST  = 304
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DOT_W-1:0]  dot,
  input  logic [LINE_W-1:0] line,
  input  logic              render_en,
  input  logic              addr_wr,
  input  logic [7:0]        wdata,
  input  logic              data_acc,
  input  logic              step32,
  output logic [14:0]       vaddr,
  output logic [4:0]        coarse_x,
  output logic [4:0]        coarse_y,
  output logic [1:0]        nt_sel,
  output logic [2:0]        fine_y
);
  localparam logic [DOT_W-1:0]  L_FETCH_END = DOT_W'(FETCH_END);
  localparam logic [DOT_W-1:0]  L_HCOPY     = DOT_W'(HCOPY_DOT);
  localparam logic [DOT_W-1:0]  L_PREF_LO   = DOT_W'(PREF_FIRST);
  localparam logic [DOT_W-1:0]  L_PREF_HI   = DOT_W'(PREF_LAST);
  localparam logic [DOT_W-1:0]  L_VC_LO     = DOT_W'(VCOPY_FIRST);
  localparam logic [DOT_W-1:0]  L_VC_HI     = DOT_W'(VCOPY_LAST);
  localparam logic [LINE_W-1:0] L_VIS       = LINE_W'(VIS_LINES);
  localparam logic [LINE_W-1:0] L_PRE       = LINE_W'(PRE_LINE);

  logic [14:0] v_q, t_q, walk, v_next;
  logic        second_q;
  logic        on_vis, on_pre, active, fetch_dot;
  logic        inc_x, inc_y, hcopy, vcopy, cpu_load;

  function automatic logic [14:0] step_x(input logic [14:0] a);
    logic [14:0] r;
    r = a;
    if (a[4:0] == 5'd31) begin
      r[4:0] = 5'd0;
      r[10]  = ~a[10];
    end else begin
      r[4:0] = a[4:0] + 5'd1;
    end
    return r;
  endfunction

  function automatic logic [14:0] step_y(input logic [14:0] a);
    logic [14:0] r;
    r = a;
    if (a[14:12] != 3'd7) begin
      r[14:12] = a[14:12] + 3'd1;
    end else begin
      r[14:12] = 3'd0;
      if (a[9:5] == 5'd29) begin
        r[9:5] = 5'd0;
        r[11]  = ~a[11];
      end else if (a[9:5] == 5'd31) begin
        r[9:5] = 5'd0;
      end else begin
        r[9:5] = a[9:5] + 5'd1;
      end
    end
    return r;
  endfunction

  assign on_vis    = line < L_VIS;
  assign on_pre    = line == L_PRE;
  assign active    = render_en && (on_vis || on_pre);
  assign fetch_dot = (dot[2:0] == 3'd0) && (dot != '0) &&
                     ((dot <= L_FETCH_END) || ((dot >= L_PREF_LO) && (dot <= L_PREF_HI)));
  assign inc_x     = active && (fetch_dot || data_acc);
  assign inc_y     = active && ((dot == L_FETCH_END) || data_acc);
  assign hcopy     = active && (dot == L_HCOPY);
  assign vcopy     = render_en && on_pre && (dot >= L_VC_LO) && (dot <= L_VC_HI);
  assign cpu_load  = addr_wr && second_q;

  always_comb begin
    walk = v_q;
    if (inc_x) walk = step_x(walk);
    if (inc_y) walk = step_y(walk);
    if (hcopy) begin
      walk[10]  = t_q[10];
      walk[4:0] = t_q[4:0];
    end
    if (vcopy) begin
      walk[14:11] = t_q[14:11];
      walk[9:5]   = t_q[9:5];
    end
    if (data_acc && !active) walk = v_q + (step32 ? 15'd32 : 15'd1);
  end

  assign v_next = cpu_load ? {t_q[14:8], wdata} : walk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q      <= '0;
      t_q      <= '0;
      second_q <= 1'b0;
    end else begin
      v_q <= v_next;
      if (addr_wr) begin
        second_q <= ~second_q;
        if (second_q) t_q[7:0]  <= wdata;
        else          t_q[14:8] <= wdata[6:0];
      end
    end
  end

  assign vaddr    = v_q;
  assign fine_y   = v_q[14:12];
  assign nt_sel   = v_q[11:10];
  assign coarse_y = v_q[9:5];
  assign coarse_x = v_q[4:0];

  a_r3_second_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_wr && second_q) |=> (vaddr[7:0] == $past(wdata)));

  a_r3_first_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_wr && !second_q && !active && !data_acc) |=> $stable(vaddr));

  a_r4_x_wrap_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (active && fetch_dot && !addr_wr && coarse_x == 5'd31) |=>
      (coarse_x == 5'd0 && nt_sel[0] != $past(nt_sel[0])));

  a_r5_fine_y_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (render_en && on_vis && !addr_wr && !data_acc && dot != L_FETCH_END) |=>
      $stable(fine_y));

  a_r5_row_stays_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (coarse_y < 5'd30 && !addr_wr && !data_acc && !(render_en && on_pre)) |=>
      (coarse_y < 5'd30));

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !addr_wr && !data_acc && !vcopy) |=> $stable(vaddr));
endmodule

// File: tb/tile_addr_walker_test.sv
module tile_addr_walker_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] dot = '0;
  logic [8:0] line = 9'd245;
  logic       render_en = 1'b0;
  logic       addr_wr = 1'b0;
  logic [7:0] wdata = '0;
  logic       data_acc = 1'b0;
  logic       step32 = 1'b0;
  logic [14:0] vaddr;
  logic [4:0]  coarse_x, coarse_y;
  logic [1:0]  nt_sel;
  logic [2:0]  fine_y;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tile_addr_walker uut (
    .clk(clk), .rst_n(rst_n), .dot(dot), .line(line), .render_en(render_en),
    .addr_wr(addr_wr), .wdata(wdata), .data_acc(data_acc), .step32(step32),
    .vaddr(vaddr), .coarse_x(coarse_x), .coarse_y(coarse_y),
    .nt_sel(nt_sel), .fine_y(fine_y)
  );

  task automatic check(input string tag, input logic [14:0] exp);
    checks++;
    if (vaddr !== exp || fine_y !== exp[14:12] || nt_sel !== exp[11:10] ||
        coarse_y !== exp[9:5] || coarse_x !== exp[4:0]) begin
      errors++;
      $display("FAIL %s: vaddr=%h fy=%0d nt=%0d cy=%0d cx=%0d expected %h",
               tag, vaddr, fine_y, nt_sel, coarse_y, coarse_x, exp);
    end
  endtask

  task automatic cycle(input logic [8:0] d, input logic [8:0] l, input logic ren,
                       input logic acc, input logic wr, input logic [7:0] b);
    @(negedge clk);
    dot = d; line = l; render_en = ren; data_acc = acc; addr_wr = wr; wdata = b;
    @(negedge clk);
    data_acc = 1'b0; addr_wr = 1'b0; render_en = 1'b0; line = 9'd245; dot = 9'd1;
  endtask

  task automatic load(input logic [7:0] hi, input logic [7:0] lo);
    cycle(9'd1, 9'd245, 1'b0, 1'b0, 1'b1, hi);
    cycle(9'd1, 9'd245, 1'b0, 1'b0, 1'b1, lo);
  endtask

  task automatic t_reset;
    check("R1 reset value", 15'h0000);
  endtask

  task automatic t_cpu_write;
    cycle(9'd1, 9'd245, 1'b0, 1'b0, 1'b1, 8'h3F);
    check("R3 first write leaves address", 15'h0000);
    cycle(9'd1, 9'd245, 1'b0, 1'b0, 1'b1, 8'hA5);
    check("R2 R3 second write copies", 15'h3FA5);
  endtask

  task automatic t_linear;
    load(8'h12, 8'h34);
    step32 = 1'b1;
    cycle(9'd1, 9'd245, 1'b0, 1'b1, 1'b0, 8'h00);
    check("R10 idle access +32", 15'h1254);
    step32 = 1'b0;
    cycle(9'd1, 9'd245, 1'b0, 1'b1, 1'b0, 8'h00);
    check("R10 idle access +1", 15'h1255);
    load(8'h7F, 8'hFF);
    cycle(9'd1, 9'd245, 1'b0, 1'b1, 1'b0, 8'h00);
    check("R10 15-bit wrap", 15'h0000);
  endtask

  task automatic t_x_wrap;
    load(8'h00, 8'h1F);
    cycle(9'd8, 9'd5, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R4 coarse X wrap toggles nt bit 10", 15'h0400);
  endtask

  task automatic t_full_line;
    load(8'h05, 8'h23);
    for (int d = 0; d <= 256; d++) cycle(9'(d), 9'd10, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R4 R5 after 32 fetch steps and dot 256", 15'h1123);
    cycle(9'd257, 9'd10, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R6 horizontal copy at 257", 15'h1523);
    for (int d = 258; d <= 340; d++) cycle(9'(d), 9'd10, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R4 34 steps per line", 15'h1525);
  endtask

  task automatic t_y_wrap;
    load(8'h73, 8'hA0);
    cycle(9'd256, 9'd20, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R5 row 29 wraps and toggles nt bit 11", 15'h0801);
    load(8'h73, 8'hE0);
    cycle(9'd256, 9'd20, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R5 row 31 wraps without toggle", 15'h0001);
  endtask

  task automatic t_prerender;
    load(8'h00, 8'h00);
    cycle(9'd1, 9'd245, 1'b0, 1'b0, 1'b1, 8'h7D);
    check("R3 pending first write leaves address", 15'h0000);
    cycle(9'd280, 9'd261, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R8 no vertical copy with rendering off", 15'h0000);
    cycle(9'd280, 9'd261, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R7 vertical copy on pre-render line", 15'h7900);
    cycle(9'd257, 9'd261, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R8 no horizontal copy with rendering off", 15'h7900);
    cycle(9'd256, 9'd261, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R8 no increment with rendering off", 15'h7900);
    cycle(9'd257, 9'd261, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R6 horizontal copy on pre-render line", 15'h7D00);
    cycle(9'd8, 9'd245, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R8 no step outside rendering lines", 15'h7D00);
    cycle(9'd1, 9'd245, 1'b0, 1'b0, 1'b1, 8'h00);
    check("R3 second write reloads", 15'h7D00);
  endtask

  task automatic t_render_access;
    cycle(9'd3, 9'd50, 1'b1, 1'b1, 1'b0, 8'h00);
    check("R9 access during rendering steps X and Y", 15'h0D21);
    cycle(9'd256, 9'd50, 1'b1, 1'b1, 1'b0, 8'h00);
    check("R9 access on dot 256 steps once", 15'h1D22);
    cycle(9'd1, 9'd245, 1'b0, 1'b0, 1'b1, 8'h12);
    cycle(9'd8, 9'd50, 1'b1, 1'b0, 1'b1, 8'h34);
    check("R3 second write overrides fetch step", 15'h1234);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_cpu_write;
        t_linear;
        t_x_wrap;
        t_full_line;
        t_y_wrap;
        t_prerender;
        t_render_access;
      end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule